// File: doc/BRIEF.md
# Interrupt Wakeup and Tie-Break Arbiter

The block watches a vector of level-sensitive interrupt requests. It does two things with them. First, it raises a wakeup request to the power manager while the core sits in a low-power mode. Second, it names one winning request for the interrupt logic that follows.

Each source has a wakeup-enable bit and a 3-bit priority level, and both are programmed through a small register write and read port. In the light low-power mode (SLEEP) any enabled, active source wakes the core. In the deep mode (STOP) only the external interrupt pins may do so. Outside both modes the wakeup stays low.

Arbitration first compares the programmed levels, where a larger level wins. Sources tied at the same level are ordered by a fixed chain in which source index 0 comes first. A source programmed to level 0 never wins. The wakeup is available both as a combinational signal and as a registered copy one cycle later, so the power manager can take a glitch-free version.

Top module: `wk_arb_top`

## Requirements
- R1: After reset all wakeup-enable bits and all levels are 0. With no request active, `wake_now`, `wake_q` and `win_valid` are low, and every register address reads 0.
- R2: Address 0 holds the wakeup-enable register, with source i at bit 31-i. Bits 3:0 always read 0, and a write of all ones reads back as 32'hFFFF_FFF0.
- R3: With `mode` = 2'b01 (SLEEP), `wake_now` is high exactly when some source is both active and enabled.
- R4: With `mode` = 2'b10 (STOP), `wake_now` is high only when an active, enabled source lies in the external set EXT_MASK. By default these are indices 0-3, 9 and 10, so a timer source at index 4 cannot wake the core.
- R5: With `mode` = 2'b00 (RUN) or the unused code 2'b11, `wake_now` stays low.
- R6: `wake_q` equals the value `wake_now` had at the previous rising clock edge.
- R7: Level words sit at addresses 1 to 4. Source 8k+j uses bits 4j+2:4j of address 1+k. Bit 4j+3 and the nibbles of nonexistent sources read 0.
- R8: Among active sources with a nonzero level, the winner has the largest level. `win_level` reports that level and `win_idx` reports the winner's index.
- R9: Among active sources tied at the winning level, the lowest index wins.
- R10: A source at level 0 never wins. `win_valid` is low when no active source has a nonzero level.
- R11: Addresses above 4 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Power mode: 00 RUN, 01 SLEEP, 10 STOP, 11 unused |
| src_req | input | NUM_SRC | Level-sensitive source requests, index 0 first in the chain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Combinational register read data |
| wake_now | output | 1 | Combinational wakeup request |
| wake_q | output | 1 | Registered wakeup request |
| win_valid | output | 1 | A winner exists |
| win_level | output | 3 | Level of the winner |
| win_idx | output | $clog2(NUM_SRC) | Index of the winner |

## Verification
On every cycle the assertions check several rules:
- Reserved enable bits read zero.
- SLEEP always wakes on an enabled, active source.
- STOP never wakes without an external one.
- RUN stays quiet.
- The registered wakeup trails the combinational one by one cycle.
- A valid winner is always active and has a nonzero level.

Only the bench's scenarios can show that the winner is the right one among ties and levels, that the level fields are laid out and masked as stated, and that a timer source wakes from SLEEP but not from STOP.

// File: rtl/wk_arb_pkg.sv
package wk_arb_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_STOP  = 2'b10,
        MODE_RSVD  = 2'b11
    } pwr_mode_e;

    localparam int LVL_W     = 3;
    localparam int REG_W     = 32;
    localparam int SLOT_W    = 4;
    localparam int SLOTS     = REG_W / SLOT_W;
    localparam int RSVD_BITS = 4;
endpackage

// File: rtl/wk_arb_regs.sv
module wk_arb_regs
    import wk_arb_pkg::*;
#(
    parameter int NUM_SRC = 28,
    parameter int ADDR_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [REG_W-1:0]              wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [REG_W-1:0]              rd_data,
    output logic [NUM_SRC-1:0]            wake_en,
    output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl
);
    typedef struct packed {
        logic [NUM_SRC-1:0]            en;
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_addr == '0)
                    state_d.en[i] = wr_data[REG_W-1-i];
                if (wr_addr == ADDR_W'(1 + i / SLOTS))
                    state_d.lvl[i] = wr_data[SLOT_W*(i % SLOTS) +: LVL_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_addr == '0)
                rd_data[REG_W-1-i] = state_q.en[i];
            if (rd_addr == ADDR_W'(1 + i / SLOTS))
                rd_data[SLOT_W*(i % SLOTS) +: LVL_W] = state_q.lvl[i];
        end
    end

    assign wake_en = state_q.en;
    assign src_lvl = state_q.lvl;
endmodule

// File: rtl/wk_arb_pick.sv
module wk_arb_pick
    import wk_arb_pkg::*;
#(
    parameter int NUM_SRC = 28,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            src_req,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    output logic                          win_valid,
    output logic [LVL_W-1:0]              win_level,
    output logic [IDX_W-1:0]              win_idx
);
    always_comb begin
        win_level = '0;
        win_idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_req[i] && (src_lvl[i] > win_level)) begin
                win_level = src_lvl[i];
                win_idx   = IDX_W'(i);
            end
        end
        win_valid = (win_level != '0);
    end
endmodule

// File: rtl/wk_arb_wake.sv
module wk_arb_wake
    import wk_arb_pkg::*;
#(
    parameter int                 NUM_SRC  = 28,
    parameter logic [NUM_SRC-1:0] EXT_MASK = 28'h000060F
) (
    input  logic [1:0]         mode,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] wake_en,
    output logic               wake_now
);
    logic [NUM_SRC-1:0] armed;

    always_comb begin
        armed = src_req & wake_en;
        unique case (pwr_mode_e'(mode))
            MODE_SLEEP: wake_now = |armed;
            MODE_STOP:  wake_now = |(armed & EXT_MASK);
            default:    wake_now = 1'b0;
        endcase
    end
endmodule

// File: rtl/wk_arb_top.sv
module wk_arb_top
    import wk_arb_pkg::*;
#(
    parameter int                 NUM_SRC  = 28,
    parameter logic [NUM_SRC-1:0] EXT_MASK = 28'h000060F,
    parameter int                 ADDR_W   = 3,
    localparam int                IDX_W    = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic                 wake_now,
    output logic                 wake_q,
    output logic                 win_valid,
    output logic [2:0]           win_level,
    output logic [IDX_W-1:0]     win_idx
);
    logic [NUM_SRC-1:0]            wake_en;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;

    typedef struct packed {
        logic wake;
    } top_state_t;

    top_state_t state_d, state_q;

    wk_arb_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wake_en (wake_en),
        .src_lvl (src_lvl)
    );

    wk_arb_wake #(.NUM_SRC(NUM_SRC), .EXT_MASK(EXT_MASK)) i_wake (
        .mode     (mode),
        .src_req  (src_req),
        .wake_en  (wake_en),
        .wake_now (wake_now)
    );

    wk_arb_pick #(.NUM_SRC(NUM_SRC)) i_pick (
        .src_req   (src_req),
        .src_lvl   (src_lvl),
        .win_valid (win_valid),
        .win_level (win_level),
        .win_idx   (win_idx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.wake = wake_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wake_q = state_q.wake;
endmodule

// File: rtl/wk_arb_chk.sv
module wk_arb_chk #(
    parameter int                 NUM_SRC  = 28,
    parameter logic [NUM_SRC-1:0] EXT_MASK = 28'h000060F,
    parameter int                 ADDR_W   = 3,
    localparam int                IDX_W    = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode,
    input logic [NUM_SRC-1:0] src_req,
    input logic [NUM_SRC-1:0] wake_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [31:0]        rd_data,
    input logic               wake_now,
    input logic               wake_q,
    input logic               win_valid,
    input logic [2:0]         win_level,
    input logic [IDX_W-1:0]   win_idx
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data[3:0] == 4'h0));

    assert_sleep_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01) && ((src_req & wake_en) != '0)) |-> wake_now);

    assert_stop_ext_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b10) && ((src_req & wake_en & EXT_MASK) == '0)) |-> !wake_now);

    assert_run_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b00) || (mode == 2'b11)) |-> !wake_now);

    assert_wake_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wake_q == $past(wake_now)));

    assert_winner_sane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((win_level != 3'd0) && src_req[win_idx]));

    assert_no_req_no_win_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0) |-> !win_valid);
endmodule

bind wk_arb_top wk_arb_chk #(
    .NUM_SRC  (NUM_SRC),
    .EXT_MASK (EXT_MASK),
    .ADDR_W   (ADDR_W)
) i_wk_arb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .src_req   (src_req),
    .wake_en   (wake_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wake_now  (wake_now),
    .wake_q    (wake_q),
    .win_valid (win_valid),
    .win_level (win_level),
    .win_idx   (win_idx)
);

// File: tb/test_wk_arb_top.sv
module test_wk_arb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 28;
    localparam logic [N-1:0] EXT       = 28'h000060F;
    localparam int          TMR_IDX    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [N-1:0] src_req = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wake_now, wake_q, win_valid;
    logic [2:0]  win_level;
    logic [4:0]  win_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    wk_arb_top i_wk_arb_top (
        .clk(clk), .rst_n(rst_n), .mode(mode), .src_req(src_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wake_now(wake_now),
        .wake_q(wake_q), .win_valid(win_valid), .win_level(win_level),
        .win_idx(win_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    function automatic logic [2:0] lvl_of(input int i);
        return 3'((i * 3) % 8);
    endfunction

    function automatic logic exp_wake(input logic [1:0] m, input logic [N-1:0] r,
                                      input logic [N-1:0] e);
        if (m == 2'b01) return |(r & e);
        if (m == 2'b10) return |(r & e & EXT);
        return 1'b0;
    endfunction

    task automatic arb_chk(input string tag, input logic [N-1:0] r);
        logic [2:0] bl;
        logic [4:0] bi;
        bl = '0; bi = '0;
        for (int i = 0; i < N; i++)
            if (r[i] && lvl_of(i) > bl) begin bl = lvl_of(i); bi = 5'(i); end
        @(negedge clk);
        src_req = r;
        #1;
        chk({tag, " valid"}, {31'd0, win_valid}, {31'd0, bl != 0});
        chk({tag, " level"}, {29'd0, win_level}, {29'd0, bl});
        if (bl != 0) chk({tag, " index"}, {27'd0, win_idx}, {27'd0, bi});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] en_full;
        logic [31:0]  x;
        en_full = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        for (int a = 0; a < 8; a++) read_chk("R1 read after reset", 3'(a), 32'h0);
        chk("R1 wake_now", {31'd0, wake_now}, 32'd0);
        chk("R1 wake_q", {31'd0, wake_q}, 32'd0);
        chk("R1 win_valid", {31'd0, win_valid}, 32'd0);

        // R2: reserved enable bits
        write_reg(3'd0, 32'hFFFF_FFFF);
        read_chk("R2 enable readback", 3'd0, 32'hFFFF_FFF0);
        write_reg(3'd0, 32'h0000_000F);
        read_chk("R2 reserved write ignored", 3'd0, 32'h0);

        // R7: level field masking
        for (int k = 1; k <= 4; k++) write_reg(3'(k), 32'hFFFF_FFFF);
        for (int k = 1; k <= 3; k++) read_chk("R7 level mask", 3'(k), 32'h7777_7777);
        read_chk("R7 partial word", 3'd4, 32'h0000_7777);

        // R11: out-of-range addresses
        write_reg(3'd5, 32'hFFFF_FFFF);
        write_reg(3'd7, 32'hFFFF_FFFF);
        for (int a = 5; a < 8; a++) read_chk("R11 unused address", 3'(a), 32'h0);
        read_chk("R11 enable untouched", 3'd0, 32'h0);

        // R3 R4 R5 R6: wake sweep over modes, sources, enable patterns
        for (int p = 0; p < 2; p++) begin
            logic [N-1:0] en;
            en = (p == 0) ? '0 : en_full;
            write_reg(3'd0, (p == 0) ? 32'h0 : 32'hFFFF_FFF0);
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < N; s++) begin
                    logic ew;
                    ew = exp_wake(2'(m), N'(1) << s, en);
                    @(negedge clk);
                    mode = 2'(m);
                    src_req = N'(1) << s;
                    #1;
                    chk((m == 1) ? "R3 sleep wake" : (m == 2) ? "R4 stop wake" : "R5 run quiet",
                        {31'd0, wake_now}, {31'd0, ew});
                    @(negedge clk);
                    chk("R6 registered wake", {31'd0, wake_q}, {31'd0, ew});
                end
            end
        end

        // R3 R4: timer source enabled alone
        write_reg(3'd0, 32'h1 << (31 - TMR_IDX));
        @(negedge clk); mode = 2'b01; src_req = N'(1) << TMR_IDX; #1;
        chk("R3 timer wakes from sleep", {31'd0, wake_now}, 32'd1);
        @(negedge clk); mode = 2'b10; #1;
        chk("R4 timer blocked in stop", {31'd0, wake_now}, 32'd0);
        @(negedge clk); mode = 2'b00; src_req = '0;

        // program levels: source i gets (3*i) mod 8
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            w = '0;
            for (int j = 0; j < 8; j++)
                if (k*8 + j < N) w[4*j +: 3] = lvl_of(k*8 + j);
            write_reg(3'(k + 1), w);
            read_chk("R7 level readback", 3'(k + 1), w);
        end

        // R9: ties resolve to lower index
        arb_chk("R9 tie 1 vs 9", (N'(1) << 1) | (N'(1) << 9));
        arb_chk("R9 tie 9 vs 17", (N'(1) << 9) | (N'(1) << 17));
        // R10: level-0 sources never win
        arb_chk("R10 level zero only", (N'(1) << 0) | (N'(1) << 8) | (N'(1) << 16));
        arb_chk("R10 no request", '0);
        // R8: single sources and pseudo-random patterns
        for (int s = 0; s < N; s++) arb_chk("R8 single", N'(1) << s);
        x = 32'h1234_5679;
        for (int t = 0; t < 200; t++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            arb_chk("R8 pattern", N'(x));
        end

        finish_run();
    end
endmodule